// File: doc/BRIEF.md
# Inverse Gamma Lookup Stage

This block applies inverse gamma correction to a pixel stream. Each pixel arrives as three 8-bit colour components. Each component is mapped through its own 256-entry table of 12-bit values, and the corrected result leaves one clock later. The table source can be one of three:

- a programmable RAM, which software loads;
- a fixed curve, ROM0;
- a fixed curve, ROM1.

Correction can also be turned off. In that case each component is passed through, zero-extended to 12 bits.

Software reaches the tables through a small register port. Each component has one streaming data register, and a per-component index moves forward on every access. A flag inside the written word restarts that index. A second flag combination rewinds the index for read-back and leaves the table untouched. An active-low mask in the written word decides which pipe instances take the write. Each instance knows its own number through the `INST` parameter.

Top module: `igc_lut`

## Requirements
- R1: After reset, correction is off, the mode register at offset 0x30 reads 0, the outputs are 0 with `out_valid` low, and every component index points at entry 0.
- R2: A write to a RAM data register stores bits [11:0] in the entry at that component's index and then advances the index. When bit 25 is set and bit 24 is clear, the entry written is entry 0 and the index then moves to 1. Bits above 11 other than the flags and mask do not change the stored value.
- R3: The RAM data registers for the three components sit at 0x00, 0x04 and 0x08. Each component keeps its own table and its own index.
- R4: Bits [30:28] of a written data word are an active-low instance mask, with bit 28+k belonging to instance k. A write whose bit for this instance is 1 changes no entry and no index.
- R5: A write with bits 25 and 24 both set resets the addressed component's index to 0 and writes no entry. A read of a data register returns the indexed entry in bits [11:0], with zeros above, and advances the index.
- R6: The index wraps from entry 255 back to entry 0, for writes and for reads.
- R7: When bit 0 of the mode register is 0, each output component equals its input zero-extended to 12 bits.
- R8: When bit 0 is 1, mode bits [2:1] pick the table. Value 0 (and 3) selects the RAM, 1 selects ROM0 and 2 selects ROM1. Both ROMs hold the curve where entry i is i shifted left by 4.
- R9: The ROM windows sit at 0x10–0x18 (ROM0) and 0x20–0x28 (ROM1). Reads there return the ROM curve at the component index. Data writes there leave both the tables and the index unchanged, while control writes still rewind the index.
- R10: The corrected pixel and `out_valid` appear exactly one clock after `pix_valid`. A table write in the same cycle as a lookup is seen only by later lookups.
- R11: The mode register at 0x30 stores bits [2:0] of a write and reads them back in bits [2:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (advances index on data registers) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data word |
| reg_rdata | output | 32 | Read data, combinational from address and index |
| pix_valid | input | 1 | Input pixel strobe |
| pix_c0 | input | 8 | Component 0 input |
| pix_c1 | input | 8 | Component 1 input |
| pix_c2 | input | 8 | Component 2 input |
| out_valid | output | 1 | Output pixel strobe |
| out_c0 | output | 12 | Corrected component 0 |
| out_c1 | output | 12 | Corrected component 1 |
| out_c2 | output | 12 | Corrected component 2 |

## Verification
A read result is combinational. It is due in the same cycle the read is driven, and the bench samples it one step after driving, before the clock edge that advances the index. A write takes effect at the next rising edge, so it is observed only through a later read or pixel.

A pixel result and `out_valid` are due exactly one edge after `pix_valid`. The bench drives on the falling edge and checks on the following falling edge. The same-cycle write test checks the old entry on the first result and the new entry on the second.

// File: rtl/igc_lut.sv
module igc_lut #(
  parameter int INST  = 0,
  parameter int PIX_W = 8,
  parameter int LUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_c0,
  input  logic [PIX_W-1:0] pix_c1,
  input  logic [PIX_W-1:0] pix_c2,
  output logic             out_valid,
  output logic [LUT_W-1:0] out_c0,
  output logic [LUT_W-1:0] out_c1,
  output logic [LUT_W-1:0] out_c2
);
  localparam int DEPTH = 1 << PIX_W;
  localparam int SH    = LUT_W - PIX_W;

  logic [LUT_W-1:0] lut [3][DEPTH];
  logic [PIX_W-1:0] idx [3];
  logic [2:0]       mode;
  logic [PIX_W-1:0] pin [3];
  logic [LUT_W-1:0] pout [3];

  wire       in_blk   = (reg_addr[7:6] == 2'd0) && (reg_addr[1:0] == 2'd0);
  wire [1:0] win      = reg_addr[5:4];
  wire [1:0] comp     = reg_addr[3:2];
  wire       data_hit = in_blk && (win != 2'd3) && (comp != 2'd3);
  wire       mode_hit = in_blk && (win == 2'd3) && (comp == 2'd0);
  wire       sel      = !reg_wdata[28 + INST];
  wire       ctl      = reg_wdata[25] && reg_wdata[24];
  wire       restart  = reg_wdata[25];
  wire       wr_data  = reg_wr && data_hit && sel;
  wire       ram_wr   = wr_data && (win == 2'd0) && !ctl;
  wire       use_ram  = (mode[2:1] == 2'd0) || (mode[2:1] == 2'd3);

  logic [PIX_W-1:0] cur_idx;
  logic [PIX_W-1:0] wr_idx;
  logic [LUT_W-1:0] rd_entry;

  always_comb begin
    cur_idx  = (comp == 2'd3) ? '0 : idx[comp];
    wr_idx   = restart ? '0 : cur_idx;
    rd_entry = (win == 2'd0 && comp != 2'd3) ? lut[comp][cur_idx]
                                             : (LUT_W'(cur_idx) << SH);
  end

  assign reg_rdata = mode_hit ? {29'd0, mode} :
                     data_hit ? 32'(rd_entry) : 32'd0;

  always_ff @(posedge clk)
    if (ram_wr) lut[comp][wr_idx] <= reg_wdata[LUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) idx[k] <= '0;
      mode <= 3'd0;
    end else begin
      if (wr_data) begin
        if (ctl) idx[comp] <= '0;
        else if (win == 2'd0) idx[comp] <= wr_idx + 1'b1;
      end else if (reg_rd && data_hit) begin
        idx[comp] <= cur_idx + 1'b1;
      end
      if (reg_wr && mode_hit) mode <= reg_wdata[2:0];
    end
  end

  assign pin[0] = pix_c0;
  assign pin[1] = pix_c1;
  assign pin[2] = pix_c2;

  for (genvar k = 0; k < 3; k++) begin : g_comp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pout[k] <= '0;
      else if (pix_valid) begin
        if (!mode[0])     pout[k] <= LUT_W'(pin[k]);
        else if (use_ram) pout[k] <= lut[k][pin[k]];
        else              pout[k] <= LUT_W'(pin[k]) << SH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;

  assign out_c0 = pout[0];
  assign out_c1 = pout[1];
  assign out_c2 = pout[2];

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid); // R10
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !mode[0] && !(reg_wr && mode_hit)) |=> out_c0 == LUT_W'($past(pix_c0))); // R7
  AST_ROM_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && mode == 3'b011) |=> out_c1 == (LUT_W'($past(pix_c1)) << SH)); // R8
  AST_MASKED_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && data_hit && !sel && !reg_rd) |=> $stable(idx[0])); // R4
  AST_ROM_WRITE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && data_hit && win != 2'd0 && !ctl && !reg_rd) |=> $stable(idx[0])); // R9
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && data_hit && comp == 2'd0 && idx[0] == '1) |=> idx[0] == '0); // R6
endmodule

// File: tb/test_igc_lut.sv
module test_igc_lut;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        pix_valid = 0;
  logic [7:0]  pix_c0 = 0, pix_c1 = 0, pix_c2 = 0;
  logic        out_valid;
  logic [11:0] out_c0, out_c1, out_c2;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] M_ME    = 32'h6000_0000;
  localparam logic [31:0] M_OTHER = 32'h5000_0000;
  localparam logic [31:0] M_NONE  = 32'h7000_0000;
  localparam logic [31:0] F_RST   = 32'h0200_0000;
  localparam logic [31:0] F_CTL   = 32'h0300_0000;

  always #2 clk = ~clk;

  igc_lut i_igc_lut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_c0(pix_c0), .pix_c1(pix_c1), .pix_c2(pix_c2),
    .out_valid(out_valid), .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2)
  );

  function automatic logic [11:0] fill(int i);
    return 12'((i * 37 + 5) & 12'hfff);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic px(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    @(negedge clk);
    pix_valid = 1; pix_c0 = a; pix_c1 = b; pix_c2 = c;
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 out_valid", {31'd0, out_valid}, 0);
    check("R1 out_c0", {20'd0, out_c0}, 0);
    rd(8'h30, v); check("R1 mode", v, 0);
    rd(8'h10, v); check("R1 idx0 start", v, 32'h000);
    rd(8'h10, v); check("R1 idx0 next", v, 32'h010);
    rd(8'h24, v); check("R1 idx1 start", v, 32'h000);
    px(8'h5A, 8'h01, 8'hFF);
    check("R1 bypass c0", {20'd0, out_c0}, 32'h05A);
    check("R10 valid", {31'd0, out_valid}, 1);
    @(negedge clk);
    check("R10 valid drop", {31'd0, out_valid}, 0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(8'h00, M_ME | F_RST | 32'h123);
    wr(8'h00, M_ME | 32'h456);
    wr(8'h00, M_ME | 32'h008F_FFFF);
    wr(8'h04, M_ME | F_RST | 32'h111);
    wr(8'h04, M_ME | 32'h222);
    wr(8'h04, M_ME | 32'h333);
    wr(8'h00, M_ME | F_CTL);
    wr(8'h04, M_ME | F_CTL);
    rd(8'h00, v); check("R2 c0 e0", v, 32'h123);
    rd(8'h00, v); check("R2 c0 e1", v, 32'h456);
    rd(8'h00, v); check("R2 c0 e2 upper ignored", v, 32'hFFF);
    rd(8'h04, v); check("R3 c1 e0", v, 32'h111);
    rd(8'h04, v); check("R3 c1 e1", v, 32'h222);
    rd(8'h04, v); check("R5 c1 e2", v, 32'h333);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h00, M_ME | F_CTL);
    rd(8'h00, v); check("R5 control keeps e0", v, 32'h123);
    wr(8'h00, M_OTHER | 32'h777);
    wr(8'h00, M_NONE | F_RST | 32'h777);
    rd(8'h00, v); check("R4 masked idx unchanged", v, 32'h456);
    wr(8'h00, M_ME | F_CTL);
    rd(8'h00, v); check("R4 masked entry unchanged", v, 32'h123);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    int bad = 0;
    wr(8'h08, M_ME | F_RST | 32'(fill(0)));
    for (int i = 1; i < 256; i++) wr(8'h08, M_ME | 32'(fill(i)));
    wr(8'h08, M_ME | 32'hABC);
    wr(8'h08, M_ME | F_CTL);
    rd(8'h08, v); check("R6 write wrap e0", v, 32'hABC);
    for (int i = 1; i < 256; i++) begin
      rd(8'h08, v);
      if (v !== 32'(fill(i))) bad++;
    end
    check("R3 c2 table contents", bad, 0);
    rd(8'h08, v); check("R6 read wrap", v, 32'hABC);
  endtask

  task automatic t_pixel_ram();
    logic [31:0] v;
    wr(8'h30, 32'h1);
    rd(8'h30, v); check("R11 mode readback", v, 32'h1);
    px(8'd2, 8'd1, 8'd200);
    check("R8 ram c0", {20'd0, out_c0}, 32'hFFF);
    check("R8 ram c1", {20'd0, out_c1}, 32'h222);
    check("R8 ram c2", {20'd0, out_c2}, 32'(fill(200)));
  endtask

  task automatic t_pixel_rom();
    wr(8'h30, 32'h3);
    px(8'd7, 8'd128, 8'd255);
    check("R8 rom0 c0", {20'd0, out_c0}, 32'h070);
    check("R8 rom0 c2", {20'd0, out_c2}, 32'hFF0);
    wr(8'h30, 32'h5);
    px(8'd9, 8'd1, 8'd0);
    check("R8 rom1 c0", {20'd0, out_c0}, 32'h090);
    check("R8 rom1 c1", {20'd0, out_c1}, 32'h010);
    wr(8'h30, 32'h4);
    px(8'd33, 8'd0, 8'd0);
    check("R7 disabled bypass", {20'd0, out_c0}, 32'h021);
  endtask

  task automatic t_rom_window();
    logic [31:0] v;
    wr(8'h14, M_ME | F_CTL);
    rd(8'h14, v); check("R9 rom0 e0", v, 32'h000);
    wr(8'h14, M_ME | 32'h999);
    rd(8'h14, v); check("R9 rom write ignored idx", v, 32'h010);
    wr(8'h28, M_ME | F_CTL);
    rd(8'h28, v); rd(8'h28, v); rd(8'h28, v);
    check("R9 rom1 e2", v, 32'h020);
    wr(8'h04, M_ME | F_CTL);
    rd(8'h04, v); check("R9 ram untouched by rom write", v, 32'h111);
  endtask

  task automatic t_concurrent();
    wr(8'h30, 32'h1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = M_ME | F_RST | 32'h7E7;
    pix_valid = 1; pix_c0 = 0; pix_c1 = 0; pix_c2 = 0;
    @(negedge clk);
    reg_wr = 0;
    check("R10 lookup sees old entry", {20'd0, out_c0}, 32'h123);
    check("R10 c2 old", {20'd0, out_c2}, 32'hABC);
    @(negedge clk);
    pix_valid = 0;
    check("R10 next lookup sees new", {20'd0, out_c0}, 32'h7E7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load();
    t_mask();
    t_wrap();
    t_pixel_ram();
    t_pixel_rom();
    t_rom_window();
    t_concurrent();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule